// File: doc/BRIEF.md
# Processor Status Store Sequencer

This block copies the architected state of one processor into a 512-byte status area in memory. A single-cycle `start` pulse supplies a target address and a mode flag (wide or legacy). The block then issues a fixed series of memory writes over a valid/ready request port. Each write carries an address, a right-justified 64-bit data word and a byte-size code. Scalar state (CPU timer, clock comparator, status word, prefix, floating-point control word, clock programmable word) arrives on plain input ports. The four register files (access, floating-point, general, control) are read through a combinational bank/index read port.

The area base comes from the target address. In wide mode, a nonzero target that differs from the prefix is first moved back by 4608 bytes. The result is then masked to a 512-byte boundary below 2 GiB. Fields go out in ascending address order, one per accepted handshake. A one-cycle `done` pulse follows the final accepted write. A `start` that arrives while a dump is running has no effect.

Top module: `status_store_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `wr_valid` and `done` are low.
- R2: The area base is the target address ANDed with 0x7FFFFE00. Bits 9 to 30 are kept and every other bit is zero. This applies in legacy mode, and in wide mode when the address is zero or equals the zero-extended prefix.
- R3: In wide mode, a target address that is nonzero and differs from the zero-extended prefix has 4608 subtracted before the mask of R2 is applied.
- R4: Each field's offset from the base and its size are fixed:
  - CPU timer: offset 216, 8 bytes.
  - Clock comparator: offset 224, 8 bytes.
  - Status word: offset 256, 8 bytes.
  - Prefix: offset 264, 4 bytes.
  - Access register i (i = 0 to 15): offset 288+4i, 4 bytes, taken from the low 32 bits of the read data.
  - Floating-point slot j (j = 0 to 3): offset 352+8j, 8 bytes.
  - General register i: offset 384+4i, 4 bytes, low 32 bits.
  - Control register i: offset 448+4i, 4 bytes, low 32 bits.
- R5: The clock comparator is stored unchanged in wide mode. In legacy mode it is shifted left by 8 bits, which drops its top byte.
- R6: `rd_bank` encodes 0 = access, 1 = floating-point, 2 = general, 3 = control. Floating-point slot j reads register 2j in legacy mode and register j in wide mode.
- R7: In wide mode only, the floating-point control word is written at offset 268 and the clock programmable word at offset 272, each 4 bytes.
- R8: A one-byte mode indicator is written at offset 163 only when the raw target address is zero. Its value is 1 in wide mode and 0 in legacy mode.
- R9: `wr_size` encodes the byte count as log2 (0 = 1 byte, 2 = 4 bytes, 3 = 8 bytes). The field value sits in the low bytes of `wr_data`, with all higher bits zero. The most significant byte of the field goes to the lowest address (big-endian).
- R10: Writes go out in strictly ascending address order, one per cycle with `wr_valid` and `wr_ready` both high. While `wr_ready` is low, address, data and size hold stable.
- R11: `done` is high for exactly one cycle, the cycle after the final accepted write, and `wr_valid` is low in that cycle.
- R12: `start` is ignored while `wr_valid` is high. A `start` in the `done` cycle launches a new dump.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, sampled when idle |
| tgt_addr | input | ADDR_W | Raw target absolute address |
| wide_mode | input | 1 | 1 = wide layout, 0 = legacy layout |
| prefix_in | input | 32 | Prefix register value |
| cpu_timer | input | 64 | CPU timer value |
| clk_comp | input | 64 | Clock comparator value |
| status_word | input | 64 | Current status word |
| fp_ctrl | input | 32 | Floating-point control word |
| tod_prog | input | 32 | Clock programmable word |
| rd_bank | output | 2 | Register file selected for reading |
| rd_idx | output | $clog2(NREG) | Register index within the bank |
| rd_data | input | 64 | Combinational read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the request |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 64 | Right-justified write data |
| wr_size | output | 2 | log2 of byte count |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: a `start` and the end of a dump. The bench holds `start` high through a whole dump. This places `start` in the cycle of the final accepted write, where it must be ignored, and in the `done` cycle, where it must launch a second dump. The scoreboard expects exactly two complete dumps and two `done` pulses. An extra or missing write, or a misplaced pulse, shows up as a queue mismatch or a `done` check failure. A separate mid-dump `start`, with a different address and mode, must leave the running sequence unchanged.

// File: rtl/sss_pkg.sv
package sss_pkg;

  typedef enum logic [3:0] {
    PH_ARCH, PH_TMR, PH_CLKC, PH_PSW, PH_PFX, PH_FPC, PH_TPR,
    PH_AR, PH_FPR, PH_GR, PH_CR
  } phase_e;

  typedef enum logic [1:0] {
    BANK_AR  = 2'd0,
    BANK_FPR = 2'd1,
    BANK_GR  = 2'd2,
    BANK_CR  = 2'd3
  } bank_e;

  localparam logic [63:0] ALIGN_MASK   = 64'h0000_0000_7FFF_FE00;
  localparam logic [63:0] WIDE_BACKOFF = 64'd4608;

  localparam int OFF_ARCH = 163;
  localparam int OFF_TMR  = 216;
  localparam int OFF_CLKC = 224;
  localparam int OFF_PSW  = 256;
  localparam int OFF_PFX  = 264;
  localparam int OFF_FPC  = 268;
  localparam int OFF_TPR  = 272;
  localparam int OFF_AR   = 288;
  localparam int OFF_FPR  = 352;
  localparam int OFF_GR   = 384;
  localparam int OFF_CR   = 448;

  // Base of the status area from the raw target address.
  function automatic logic [63:0] area_base(input logic [63:0] raw,
                                            input logic [31:0] pfx,
                                            input logic        wide);
    logic [63:0] adj;
    adj = raw;
    if (wide && (raw != 64'd0) && (raw != {32'd0, pfx}))
      adj = raw - WIDE_BACKOFF;
    return adj & ALIGN_MASK;
  endfunction

  function automatic logic [8:0] field_offset(input phase_e ph, input logic [7:0] i);
    case (ph)
      PH_ARCH: return 9'(OFF_ARCH);
      PH_TMR:  return 9'(OFF_TMR);
      PH_CLKC: return 9'(OFF_CLKC);
      PH_PSW:  return 9'(OFF_PSW);
      PH_PFX:  return 9'(OFF_PFX);
      PH_FPC:  return 9'(OFF_FPC);
      PH_TPR:  return 9'(OFF_TPR);
      PH_AR:   return 9'(OFF_AR + 4 * int'(i));
      PH_FPR:  return 9'(OFF_FPR + 8 * int'(i));
      PH_GR:   return 9'(OFF_GR + 4 * int'(i));
      PH_CR:   return 9'(OFF_CR + 4 * int'(i));
      default: return 9'd0;
    endcase
  endfunction

  // log2 of the byte count of each field.
  function automatic logic [1:0] field_size(input phase_e ph);
    case (ph)
      PH_ARCH:                        return 2'd0;
      PH_TMR, PH_CLKC, PH_PSW, PH_FPR: return 2'd3;
      default:                        return 2'd2;
    endcase
  endfunction

  function automatic logic [63:0] comp_image(input logic [63:0] c, input logic wide);
    return wide ? c : {c[55:0], 8'h00};
  endfunction

endpackage

// File: rtl/sss_step_ctrl.sv
module sss_step_ctrl
  import sss_pkg::*;
#(
  parameter int NREG = 16,
  parameter int NFPR = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             arch_en,
  input  logic             wide_en,
  input  logic             accept,
  output phase_e           phase,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             final_step
);

  localparam logic [IDX_W-1:0] REG_LAST = IDX_W'(NREG - 1);
  localparam logic [IDX_W-1:0] FPR_LAST = IDX_W'(NFPR - 1);

  phase_e           phase_q, nxt_phase;
  logic [IDX_W-1:0] idx_q, nxt_idx;
  logic             busy_q;

  assign phase      = phase_q;
  assign idx        = idx_q;
  assign busy       = busy_q;
  assign final_step = busy_q && (phase_q == PH_CR) && (idx_q == REG_LAST);

  always_comb begin
    nxt_phase = phase_q;
    nxt_idx   = '0;
    case (phase_q)
      PH_ARCH: nxt_phase = PH_TMR;
      PH_TMR:  nxt_phase = PH_CLKC;
      PH_CLKC: nxt_phase = PH_PSW;
      PH_PSW:  nxt_phase = PH_PFX;
      PH_PFX:  nxt_phase = wide_en ? PH_FPC : PH_AR;
      PH_FPC:  nxt_phase = PH_TPR;
      PH_TPR:  nxt_phase = PH_AR;
      PH_AR: begin
        if (idx_q == REG_LAST) nxt_phase = PH_FPR;
        else nxt_idx = idx_q + IDX_W'(1);
      end
      PH_FPR: begin
        if (idx_q == FPR_LAST) nxt_phase = PH_GR;
        else nxt_idx = idx_q + IDX_W'(1);
      end
      PH_GR: begin
        if (idx_q == REG_LAST) nxt_phase = PH_CR;
        else nxt_idx = idx_q + IDX_W'(1);
      end
      PH_CR: begin
        if (idx_q != REG_LAST) nxt_idx = idx_q + IDX_W'(1);
        else nxt_idx = idx_q;
      end
      default: nxt_phase = PH_TMR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= PH_TMR;
      idx_q   <= '0;
    end else if (launch) begin
      busy_q  <= 1'b1;
      phase_q <= arch_en ? PH_ARCH : PH_TMR;
      idx_q   <= '0;
    end else if (accept) begin
      if (final_step) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        phase_q <= nxt_phase;
        idx_q   <= nxt_idx;
      end
    end
  end

endmodule

// File: rtl/sss_field_mux.sv
module sss_field_mux
  import sss_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  phase_e           phase,
  input  logic [IDX_W-1:0] idx,
  input  logic             wide,
  input  logic [63:0]      cpu_timer,
  input  logic [63:0]      clk_comp,
  input  logic [63:0]      status_word,
  input  logic [31:0]      prefix_in,
  input  logic [31:0]      fp_ctrl,
  input  logic [31:0]      tod_prog,
  input  logic [63:0]      rd_data,
  output logic [1:0]       rd_bank,
  output logic [IDX_W-1:0] rd_idx,
  output logic [8:0]       offset,
  output logic [63:0]      data,
  output logic [1:0]       size
);

  logic [IDX_W-1:0] fpr_src;

  // Legacy layout takes every second floating-point register.
  assign fpr_src = wide ? idx : IDX_W'({idx, 1'b0});

  assign offset = field_offset(phase, 8'(idx));
  assign size   = field_size(phase);

  always_comb begin
    rd_bank = BANK_AR;
    rd_idx  = idx;
    case (phase)
      PH_FPR: begin rd_bank = BANK_FPR; rd_idx = fpr_src; end
      PH_GR:  rd_bank = BANK_GR;
      PH_CR:  rd_bank = BANK_CR;
      default: rd_bank = BANK_AR;
    endcase
  end

  always_comb begin
    case (phase)
      PH_ARCH: data = {63'd0, wide};
      PH_TMR:  data = cpu_timer;
      PH_CLKC: data = comp_image(clk_comp, wide);
      PH_PSW:  data = status_word;
      PH_PFX:  data = {32'd0, prefix_in};
      PH_FPC:  data = {32'd0, fp_ctrl};
      PH_TPR:  data = {32'd0, tod_prog};
      PH_FPR:  data = rd_data;
      default: data = {32'd0, rd_data[31:0]};
    endcase
  end

endmodule

// File: rtl/status_store_seq.sv
module status_store_seq
  import sss_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int NREG   = 16,
  parameter int NFPR   = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              wide_mode,
  input  logic [31:0]       prefix_in,
  input  logic [63:0]       cpu_timer,
  input  logic [63:0]       clk_comp,
  input  logic [63:0]       status_word,
  input  logic [31:0]       fp_ctrl,
  input  logic [31:0]       tod_prog,
  output logic [1:0]        rd_bank,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [63:0]       rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [63:0]       wr_data,
  output logic [1:0]        wr_size,
  output logic              done
);

  // Named internal events, used by the bound checker.
  logic             launch_w;
  logic             accept_w;
  logic             final_accept_w;
  logic             busy_w;
  logic             final_step_w;
  logic             arch_live;
  logic [63:0]      base_live;
  logic [63:0]      base_q;
  logic             wide_q;
  logic             arch_q;
  logic             done_q;
  phase_e           phase_w;
  logic [IDX_W-1:0] idx_w;
  logic [8:0]       offset_w;

  assign launch_w       = start && !busy_w;
  assign accept_w       = busy_w && wr_ready;
  assign final_accept_w = accept_w && final_step_w;
  assign arch_live      = (tgt_addr == '0);
  assign base_live      = area_base(64'(tgt_addr), prefix_in, wide_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      wide_q <= 1'b0;
      arch_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= final_accept_w;
      if (launch_w) begin
        base_q <= base_live;
        wide_q <= wide_mode;
        arch_q <= arch_live;
      end
    end
  end

  sss_step_ctrl #(.NREG(NREG), .NFPR(NFPR)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch_w),
    .arch_en    (arch_live),
    .wide_en    (wide_q),
    .accept     (accept_w),
    .phase      (phase_w),
    .idx        (idx_w),
    .busy       (busy_w),
    .final_step (final_step_w)
  );

  sss_field_mux #(.NREG(NREG)) u_mux (
    .phase       (phase_w),
    .idx         (idx_w),
    .wide        (wide_q),
    .cpu_timer   (cpu_timer),
    .clk_comp    (clk_comp),
    .status_word (status_word),
    .prefix_in   (prefix_in),
    .fp_ctrl     (fp_ctrl),
    .tod_prog    (tod_prog),
    .rd_data     (rd_data),
    .rd_bank     (rd_bank),
    .rd_idx      (rd_idx),
    .offset      (offset_w),
    .data        (wr_data),
    .size        (wr_size)
  );

  assign wr_valid = busy_w;
  assign wr_addr  = ADDR_W'(base_q + 64'(offset_w));
  assign done     = done_q;

endmodule

// File: rtl/sss_checker.sv
module sss_checker #(
  parameter int ADDR_W = 64,
  parameter int NREG   = 16,
  parameter int NFPR   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [63:0]       wr_data,
  input logic [1:0]        wr_size,
  input logic              done,
  input logic              accept,
  input logic              wide_q,
  input logic              arch_q
);

  localparam logic [7:0] BASE_WRITES = 8'(3 * NREG + NFPR + 4);

  logic [ADDR_W-1:0] prev_addr;
  logic              have_prev;
  logic [7:0]        acc_cnt;
  logic [7:0]        exp_cnt;

  assign exp_cnt = BASE_WRITES + (wide_q ? 8'd2 : 8'd0) + (arch_q ? 8'd1 : 8'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_addr <= '0;
      have_prev <= 1'b0;
      acc_cnt   <= '0;
    end else if (start && !wr_valid) begin
      have_prev <= 1'b0;
      acc_cnt   <= '0;
    end else if (accept) begin
      prev_addr <= wr_addr;
      have_prev <= 1'b1;
      acc_cnt   <= acc_cnt + 8'd1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!wr_valid && !done));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_size)));

  assert_ascend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && have_prev) |-> (wr_addr > prev_addr));

  assert_done_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(accept) && !wr_valid));

  // Write count per dump also covers R8 (indicator byte only for zero target).
  assert_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (acc_cnt == exp_cnt));

  assert_justify_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_size == 2'd2) |-> (wr_data[63:32] == 32'd0 && wr_addr[1:0] == 2'd0));

  assert_align8_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_size == 2'd3) |-> (wr_addr[2:0] == 3'd0));

  assert_launch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(start));

endmodule

bind status_store_seq sss_checker #(.ADDR_W(ADDR_W), .NREG(NREG), .NFPR(NFPR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .wr_size  (wr_size),
  .done     (done),
  .accept   (accept_w),
  .wide_q   (wide_q),
  .arch_q   (arch_q)
);

// File: tb/tb_status_store_seq.sv
`timescale 1ns/1ps
module tb_status_store_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [63:0] tgt_addr;
  logic        wide_mode;
  logic [31:0] prefix_in;
  logic [63:0] cpu_timer, clk_comp, status_word;
  logic [31:0] fp_ctrl, tod_prog;
  logic [1:0]  rd_bank;
  logic [3:0]  rd_idx;
  logic [63:0] rd_data;
  logic        wr_valid, wr_ready;
  logic [63:0] wr_addr, wr_data;
  logic [1:0]  wr_size;
  logic        done;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_store_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_addr(tgt_addr),
    .wide_mode(wide_mode), .prefix_in(prefix_in), .cpu_timer(cpu_timer),
    .clk_comp(clk_comp), .status_word(status_word), .fp_ctrl(fp_ctrl),
    .tod_prog(tod_prog), .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_size(wr_size), .done(done)
  );

  // Register files
  logic [63:0] ar_f [16];
  logic [63:0] fp_f [16];
  logic [63:0] gr_f [16];
  logic [63:0] cr_f [16];

  always_comb begin
    case (rd_bank)
      2'd0: rd_data = ar_f[rd_idx];
      2'd1: rd_data = fp_f[rd_idx];
      2'd2: rd_data = gr_f[rd_idx];
      default: rd_data = cr_f[rd_idx];
    endcase
  end

  logic [7:0] mem [logic [63:0]];

  typedef struct {
    logic [63:0] a;
    logic [1:0]  sz;
    logic [63:0] d;
    bit          last;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    pend_done = 0;
  bit    throttle = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [63:0] a, input logic [1:0] sz, input logic [63:0] d,
                      input bit last, input string tag);
    item_t e;
    e.a = a; e.sz = sz; e.d = d; e.last = last; e.tag = tag;
    exp_q.push_back(e);
  endtask

  function automatic logic [63:0] exp_base(input logic [63:0] raw, input bit w);
    logic [63:0] a;
    a = raw;
    if (w && raw != 64'd0 && raw != {32'd0, prefix_in}) a = raw - 64'd4608;
    return a & 64'h7FFF_FE00;
  endfunction

  // Driver side of the scoreboard: expected write list for one dump.
  task automatic plan_dump(input logic [63:0] raw, input bit w);
    logic [63:0] b;
    string at;
    b  = exp_base(raw, w);
    at = (w && raw != 64'd0 && raw != {32'd0, prefix_in}) ? "R3" : "R2";
    if (raw == 64'd0) push(b + 163, 2'd0, {63'd0, w}, 0, "R8");
    push(b + 216, 2'd3, cpu_timer, 0, at);
    push(b + 224, 2'd3, w ? clk_comp : (clk_comp << 8), 0, "R5");
    push(b + 256, 2'd3, status_word, 0, "R4");
    push(b + 264, 2'd2, {32'd0, prefix_in}, 0, "R4");
    if (w) begin
      push(b + 268, 2'd2, {32'd0, fp_ctrl}, 0, "R7");
      push(b + 272, 2'd2, {32'd0, tod_prog}, 0, "R7");
    end
    for (int i = 0; i < 16; i++) push(b + 288 + 4*i, 2'd2, {32'd0, ar_f[i][31:0]}, 0, "R4");
    for (int j = 0; j < 4; j++)  push(b + 352 + 8*j, 2'd3, w ? fp_f[j] : fp_f[2*j], 0, "R6");
    for (int i = 0; i < 16; i++) push(b + 384 + 4*i, 2'd2, {32'd0, gr_f[i][31:0]}, 0, "R4");
    for (int i = 0; i < 16; i++) push(b + 448 + 4*i, 2'd2, {32'd0, cr_f[i][31:0]}, i == 15, "R10");
  endtask

  // Ready pattern changes just after each rising edge.
  always @(posedge clk) begin
    #1;
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready <= throttle ? lfsr[0] : 1'b1;
  end

  // Monitor side of the scoreboard.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (pend_done) begin
        chk(done === 1'b1, "R11 done after final write", {63'd0, done}, 64'd1);
        pend_done = 0;
      end else if (done === 1'b1) begin
        chk(1'b0, "R11 stray done", 64'd1, 64'd0);
      end
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected write", wr_addr, 64'd0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(wr_addr === e.a, {e.tag, " address"}, wr_addr, e.a);
          chk(wr_size === e.sz, {e.tag, " size R9"}, {62'd0, wr_size}, {62'd0, e.sz});
          chk(wr_data === e.d, {e.tag, " data R9"}, wr_data, e.d);
          for (int k = 0; k < (1 << wr_size); k++)
            mem[wr_addr + 64'(k)] = 8'(wr_data >> (8 * ((1 << wr_size) - 1 - k)));
          if (e.last) pend_done = 1;
        end
      end
    end
  end

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
  endtask

  task automatic run_dump(input logic [63:0] raw, input bit w);
    plan_dump(raw, w);
    @(negedge clk);
    tgt_addr = raw; wide_mode = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; tgt_addr = '0; wide_mode = 1'b0; wr_ready = 1'b1;
    prefix_in   = 32'h0004_3000;
    cpu_timer   = 64'h1122_3344_5566_7788;
    clk_comp    = 64'hA1B2_C3D4_E5F6_0718;
    status_word = 64'h0706_0504_0302_0100;
    fp_ctrl     = 32'hF0C0_0001;
    tod_prog    = 32'h7D70_0002;
    for (int i = 0; i < 16; i++) begin
      ar_f[i] = 64'hAA00_0000_A000_0000 | 64'(i);
      fp_f[i] = 64'hF000_0000_0000_0F00 | (64'(i) << 32);
      gr_f[i] = 64'hBEEF_0000_6000_0000 | 64'(i * 3);
      cr_f[i] = 64'hC0DE_0000_C000_0000 | 64'(i * 5);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wr_valid === 1'b0 && done === 1'b0, "R1 outputs quiet in reset", {62'd0, wr_valid, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_valid === 1'b0 && done === 1'b0, "R1 outputs quiet after reset", {62'd0, wr_valid, done}, 64'd0);

    // Legacy, nonzero target: base 0x12200
    run_dump(64'h0001_2345, 1'b0);
    chk(mem[64'h12200 + 264] === 8'h00, "R9 prefix msb first", {56'd0, mem[64'h12200 + 264]}, 64'h00);
    chk(mem[64'h12200 + 265] === 8'h04, "R9 prefix byte 1", {56'd0, mem[64'h12200 + 265]}, 64'h04);
    chk(mem[64'h12200 + 216] === 8'h11, "R9 timer msb first", {56'd0, mem[64'h12200 + 216]}, 64'h11);
    chk(mem[64'h12200 + 223] === 8'h88, "R9 timer lsb last", {56'd0, mem[64'h12200 + 223]}, 64'h88);

    // Zero target, both modes (indicator byte)
    run_dump(64'd0, 1'b0);
    run_dump(64'd0, 1'b1);

    // Wide, target equals prefix: no backoff
    run_dump(64'h0004_3000, 1'b1);

    // Wide with backoff, throttled ready: base 0x104400
    throttle = 1;
    run_dump(64'h0010_5600, 1'b1);

    // High address bits masked: base 0x1E00
    run_dump(64'hFFFF_FFFF_8000_1FFF, 1'b0);

    // Start mid-dump is ignored (R12)
    plan_dump(64'h0000_8000, 1'b0);
    @(negedge clk);
    tgt_addr = 64'h0000_8000; wide_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    tgt_addr = 64'h0000_0000; wide_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    @(negedge clk);
    for (int c = 0; c < 5; c++) begin
      chk(wr_valid === 1'b0, "R12 no launch from busy start", {63'd0, wr_valid}, 64'd0);
      @(negedge clk);
    end

    // Start held high: ignored at final write, accepted in done cycle
    throttle = 0;
    plan_dump(64'h0002_0000, 1'b1);
    plan_dump(64'h0002_0000, 1'b1);
    @(negedge clk);
    tgt_addr = 64'h0002_0000; wide_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    wait_done();
    @(negedge clk);
    start = 1'b0;
    chk(wr_valid === 1'b1, "R12 relaunch in done cycle", {63'd0, wr_valid}, 64'd1);
    wait_done();
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk(wr_valid === 1'b0, "R12 only two dumps", {63'd0, wr_valid}, 64'd0);
    chk(exp_q.size() == 0, "R10 all expected writes seen", 64'(exp_q.size()), 64'd0);
    finish_run();
  end

endmodule